// File: doc/BRIEF.md
# Operand Bypass Select and Load Dependency Stall Unit

This unit sits beside the decode and execute stages of a five-stage in-order integer pipeline. It compares the source register numbers of the instruction now in execute against the destination numbers carried by the two younger-result pipeline registers: the one leaving execute, called "mem stage", and the one leaving memory, called "wb stage". It then tells each ALU operand multiplexer where to take its value from. The stage closer to execute always wins, because it holds the more recent write to that register.

The same unit also watches for a load in execute whose destination is read by the instruction now in decode. That value cannot be bypassed in time. The unit therefore freezes the program counter and the fetch/decode register for one cycle. It also asks the decode logic to zero the control fields being written into the decode/execute register, so that a bubble enters the pipeline. A one-bit state register makes sure that a single load dependency never yields more than one stall cycle.

Top module: `pipe_hazard_unit`

## Requirements
- R1: `fwd_a` is 2'b10 (take mem stage result) when `mem_wr_en` is 1, `mem_rd` is not 0 and `mem_rd` equals `ex_src_a`.
- R2: `fwd_b` is 2'b10 when `mem_wr_en` is 1, `mem_rd` is not 0 and `mem_rd` equals `ex_src_b`.
- R3: An operand select is 2'b01 (take wb stage result) when `wb_wr_en` is 1, `wb_rd` is not 0, `wb_rd` equals that operand's source, and the R1/R2 condition for that operand is false. The value 2'b11 never appears.
- R4: When both the mem stage and the wb stage condition hold for the same operand, the select is 2'b10.
- R5: A select is 2'b00 (register file) when neither stage qualifies. A stage never qualifies when its write enable is 0 or its destination is register 0.
- R6: `hold_fetch` and `bubble` are both 1 in the same cycle when `ex_mem_rd` is 1, `ex_src_b` equals `id_src_a` or `id_src_b`, and no stall was given in the previous cycle.
- R7: A stall never lasts more than one cycle. In the cycle after a stall, `hold_fetch` and `bubble` are 0 even if the R6 match is still present.
- R8: With `ex_mem_rd` at 0, or with no register match, `hold_fetch` and `bubble` are 0.
- R9: Reset clears the stall history. In the first cycle after reset, an R6 match stalls at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_src_a | input | 5 | First source register of instruction in decode |
| id_src_b | input | 5 | Second source register of instruction in decode |
| ex_src_a | input | 5 | First source register of instruction in execute |
| ex_src_b | input | 5 | Second source register of instruction in execute; the load destination |
| ex_mem_rd | input | 1 | Instruction in execute is a load |
| mem_rd | input | 5 | Destination register in the mem stage register |
| mem_wr_en | input | 1 | Mem stage instruction writes a register |
| wb_rd | input | 5 | Destination register in the wb stage register |
| wb_wr_en | input | 1 | Wb stage instruction writes a register |
| fwd_a | output | 2 | First ALU operand select |
| fwd_b | output | 2 | Second ALU operand select |
| hold_fetch | output | 1 | Hold program counter and fetch/decode register |
| bubble | output | 1 | Zero the control fields entering decode/execute |

## Verification
The hardest case to reach from the ports is a load match that persists into the cycle after a stall. A correct surrounding pipeline would already have cleared the load's read flag by then. The stimulus therefore keeps the load match driven for several cycles in a row, and it also applies that match in the first cycle after reset. Random traffic over only four register numbers produces many double matches and register-0 writes. The bench's reference model tracks the previous-cycle stall separately.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/bypass_select.sv
module bypass_select
  import hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr_en,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr_en,
  output fwd_sel_e      sel
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;

  assign mem_hit = mem_wr_en && (mem_rd != ZERO_REG) && (mem_rd == src);
  assign wb_hit  = wb_wr_en  && (wb_rd  != ZERO_REG) && (wb_rd  == src);

  always_comb begin
    if (mem_hit)     sel = SEL_MEM;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_RF;
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sel != 2'b11); // R3
  AST_ZERO_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (src == ZERO_REG) |-> (sel == SEL_RF)); // R5
  AST_NEWER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_rd == src && src != ZERO_REG) |-> (sel == SEL_MEM)); // R4
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  input  logic [AW-1:0] ld_dst,
  input  logic          ld_valid,
  output logic          stall
);
  logic match;
  logic stall_q;
  logic stall_d;
  logic stall_en;

  assign match    = ld_valid && ((ld_dst == id_src_a) || (ld_dst == id_src_b));
  assign stall    = match && !stall_q;
  assign stall_d  = stall;
  assign stall_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stall_q <= 1'b0;
    else if (stall_en) stall_q <= stall_d;
  end

  AST_ONE_CYCLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R7
  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ld_valid); // R8
  AST_STALL_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ld_dst == id_src_a || ld_dst == id_src_b)); // R6
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  input  logic [AW-1:0] ex_src_a,
  input  logic [AW-1:0] ex_src_b,
  input  logic          ex_mem_rd,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr_en,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr_en,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          hold_fetch,
  output logic          bubble
);
  localparam int NOPS = 2;

  logic [AW-1:0] op_src [NOPS];
  fwd_sel_e      op_sel [NOPS];
  logic          stall;

  assign op_src[0] = ex_src_a;
  assign op_src[1] = ex_src_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    bypass_select #(.AW(AW)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (op_src[g]),
      .mem_rd    (mem_rd),
      .mem_wr_en (mem_wr_en),
      .wb_rd     (wb_rd),
      .wb_wr_en  (wb_wr_en),
      .sel       (op_sel[g])
    );
  end

  load_use_detect #(.AW(AW)) u_lud (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_src_a (id_src_a),
    .id_src_b (id_src_b),
    .ld_dst   (ex_src_b),
    .ld_valid (ex_mem_rd),
    .stall    (stall)
  );

  assign fwd_a      = op_sel[0];
  assign fwd_b      = op_sel[1];
  assign hold_fetch = stall;
  assign bubble     = stall;

  AST_NO_WB_WHEN_MEM_A: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == 2'b01) |-> !(mem_wr_en && mem_rd == ex_src_a && mem_rd != '0)); // R1
  AST_NO_WB_WHEN_MEM_B: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b == 2'b01) |-> !(mem_wr_en && mem_rd == ex_src_b && mem_rd != '0)); // R2
endmodule

// File: tb/pipe_hazard_unit_tb.sv
module pipe_hazard_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] id_src_a, id_src_b, ex_src_a, ex_src_b, mem_rd, wb_rd;
  logic       ex_mem_rd, mem_wr_en, wb_wr_en;
  logic [1:0] fwd_a, fwd_b;
  logic       hold_fetch, bubble;

  int checks = 0;
  int errors = 0;
  bit prev_stall = 1'b0;

  always #2 clk = ~clk;

  pipe_hazard_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .id_src_a(id_src_a), .id_src_b(id_src_b),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_mem_rd(ex_mem_rd),
    .mem_rd(mem_rd), .mem_wr_en(mem_wr_en),
    .wb_rd(wb_rd), .wb_wr_en(wb_wr_en),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .hold_fetch(hold_fetch), .bubble(bubble)
  );

  function automatic int ref_sel(input logic [4:0] s, output string tag, input string mtag);
    bit m, w;
    m = mem_wr_en && mem_rd != 0 && mem_rd == s;
    w = wb_wr_en && wb_rd != 0 && wb_rd == s;
    if (m && w)      begin tag = "R4"; return 2; end
    else if (m)      begin tag = mtag; return 2; end
    else if (w)      begin tag = "R3"; return 1; end
    tag = "R5";
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] ia, ib, ea, eb, input logic ld,
                       input logic [4:0] mr, input logic mw,
                       input logic [4:0] wr, input logic ww);
    @(negedge clk);
    id_src_a = ia; id_src_b = ib; ex_src_a = ea; ex_src_b = eb; ex_mem_rd = ld;
    mem_rd = mr; mem_wr_en = mw; wb_rd = wr; wb_wr_en = ww;
    #1;
    compare();
  endtask

  task automatic compare();
    string t;
    int e;
    bit hz, st;
    e = ref_sel(ex_src_a, t, "R1"); chk(t, fwd_a, e);
    e = ref_sel(ex_src_b, t, "R2"); chk(t, fwd_b, e);
    hz = ex_mem_rd && (ex_src_b == id_src_a || ex_src_b == id_src_b);
    st = hz && !prev_stall;
    if (hz && prev_stall) t = "R7"; else if (hz) t = "R6"; else t = "R8";
    chk(t, hold_fetch, st);
    chk(t, bubble, st);
    if (rst_n) prev_stall = st;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    id_src_a = 0; id_src_b = 0; ex_src_a = 0; ex_src_b = 0; ex_mem_rd = 0;
    mem_rd = 0; mem_wr_en = 0; wb_rd = 0; wb_wr_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R5", fwd_a, 0); chk("R8", hold_fetch, 0);
    rst_n = 1'b1;
    // R9: load match in the first cycle out of reset stalls at once
    drive(5'd3, 5'd1, 5'd2, 5'd3, 1, 5'd0, 0, 5'd0, 0);
    chk("R9", bubble, 1);
    // R7: match held, no second stall; then stall again after a gap
    drive(5'd3, 5'd1, 5'd2, 5'd3, 1, 5'd0, 0, 5'd0, 0);
    drive(5'd3, 5'd1, 5'd2, 5'd3, 1, 5'd0, 0, 5'd0, 0);
    drive(5'd1, 5'd3, 5'd2, 5'd3, 0, 5'd0, 0, 5'd0, 0); // R8
    // back-to-back dependency R1/R2
    drive(5'd0, 5'd0, 5'd7, 5'd9, 0, 5'd7, 1, 5'd0, 0);
    drive(5'd0, 5'd0, 5'd7, 5'd9, 0, 5'd9, 1, 5'd0, 0);
    // distance two R3
    drive(5'd0, 5'd0, 5'd7, 5'd9, 0, 5'd4, 1, 5'd9, 1);
    // double hazard R4
    drive(5'd0, 5'd0, 5'd8, 5'd8, 0, 5'd8, 1, 5'd8, 1);
    // register 0 and write enable off R5
    drive(5'd0, 5'd0, 5'd0, 5'd0, 0, 5'd0, 1, 5'd0, 1);
    drive(5'd0, 5'd0, 5'd6, 5'd6, 0, 5'd6, 0, 5'd6, 0);
    // mem stage disabled, wb still used R3
    drive(5'd0, 5'd0, 5'd6, 5'd5, 0, 5'd6, 0, 5'd6, 1);
    // random traffic over few registers
    for (int i = 0; i < 3000; i++) begin
      drive(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)),
            5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule